// File: doc/BRIEF.md
# Turnaround Serial Link Slave

This block is the slave end of a two-wire serial link made of one clock wire and one shared data wire. Only the host drives the clock. Every transfer is a frame of twelve bit periods. The first bit period is a start marker, the last is an end marker, and the two bits after the start bit are a control code. That code decides who fills the eight data periods in the middle of the frame. Either the host writes a byte to the slave, or the slave answers with a byte on the same wire. In the second case the line direction turns around inside the frame.

Both link wires are brought into the block's own system clock through synchronizers, and their edges are detected there. The system clock must run well above the link rate. At the nominal link rate of 3.84 MHz a bit period is about 260 ns, and the block responds to each link edge within a few system cycles.

A local holding register is loaded with a ready/load handshake and supplies the byte for the next slave-owned slot. Received bytes leave on a strobe. Framing faults leave on a pulse. If the link clock stops in the middle of a frame, the block drops that frame and waits for a new one.

Top module: `hdx_frame_slave`

## Requirements
- R1: After reset, link_oe, rx_valid, frame_err and tx_underrun are 0, link_dout is 1 and tx_ready is 1.
- R2: A frame starts only when the line is sampled 0 on a rising link clock edge while no frame is open. A rising-edge sample of 1 at that point is ignored: no strobe, no error, and the next frame is still received correctly.
- R3: When the control code {bit1, bit2} is anything other than 2'b11, the host owns the data slot. Bit periods 3 to 10 are captured least significant bit first, so bit 3 is data bit 0. After an end bit sampled as 1, rx_valid pulses for one cycle with the byte on rx_data.
- R4: An end bit sampled as 0 gives a one-cycle frame_err pulse. No rx_valid is given, and rx_data keeps its previous value.
- R5: A control code of 2'b11 gives the slot to the slave. It drives the held byte least significant bit first, so bit period 3 carries data bit 0.
- R6: link_oe is 1 only from the falling link edge that opens bit 3 to the falling link edge that opens bit 11 of a slave-owned frame. It stays 0 throughout host-owned frames.
- R7: While link_oe is 1, link_dout changes only in response to falling link clock edges.
- R8: tx_ready is 1 while the holding register is empty. A tx_load while tx_ready is 1 stores tx_data and drops tx_ready. A tx_load while tx_ready is 0 is ignored. A slave-owned slot empties the register.
- R9: If the slot is given to the slave while the holding register is empty, the block sends 8'hFF and sets tx_underrun. The next accepted load clears tx_underrun.
- R10: If no link clock edge is seen for IDLE_CYC system cycles while a frame is open, the frame is abandoned and link_oe is released. The next frame is handled from its start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_clk | input | 1 | Link clock from the host, idles high |
| link_din | input | 1 | Shared data line as seen by the slave |
| link_dout | output | 1 | Value the slave drives onto the shared line |
| link_oe | output | 1 | Enable for the slave's line driver |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | DATA_W | Last byte received from the host |
| tx_data | input | DATA_W | Byte to place in the holding register |
| tx_load | input | 1 | Load request for tx_data |
| tx_ready | output | 1 | Holding register is empty and accepts a load |
| tx_underrun | output | 1 | A slave slot was served with no byte loaded |
| frame_err | output | 1 | One-cycle pulse for a bad end bit |

## Verification
The hardest states to reach from the ports are a frame cut off partway through a slave-owned slot and a bit counter left out of step by a stray pulse. Reaching them takes link clock sequences that a well-behaved host never produces. The bench drives the link clock and data wire itself, bit period by bit period. It sends a lone pulse carrying a 1 in the start position, and it sends a truncated slave frame followed by a long clock gap. After each of these it sends an ordinary frame, whose received byte and driver-enable window show whether the slave resynchronized. Random host and slave frames fill in the ordinary paths.

// File: rtl/hdx_frame_slave.sv
module hdx_frame_slave #(
  parameter int DATA_W      = 8,
  parameter int IDLE_CYC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_clk,
  input  logic              link_din,
  output logic              link_dout,
  output logic              link_oe,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  output logic              tx_ready,
  output logic              tx_underrun,
  output logic              frame_err
);

  localparam int CTRL_BITS  = 2;
  localparam int FIRST_DATA = 1 + CTRL_BITS;
  localparam int LAST_BIT   = FIRST_DATA + DATA_W;
  localparam int CW         = $clog2(LAST_BIT + 1);
  localparam int IW         = $clog2(IDLE_CYC + 1);

  logic [SYNC_STAGES-1:0] clk_sy, din_sy;
  logic                   clk_q;
  logic [CW-1:0]          bit_cnt;
  logic [CTRL_BITS-1:0]   ctrl_q;
  logic [DATA_W-1:0]      rx_sh, tx_sh, hold;
  logic                   hold_full;
  logic [IW-1:0]          idle_cnt;

  wire lclk    = clk_sy[SYNC_STAGES-1];
  wire ldin    = din_sy[SYNC_STAGES-1];
  wire rise    = lclk & ~clk_q;
  wire fall    = ~lclk & clk_q;
  wire timeout = (idle_cnt == IW'(IDLE_CYC)) && !(rise || fall) && (bit_cnt != '0);
  wire slave_now = (ctrl_q == {CTRL_BITS{1'b1}});
  wire take    = fall && !timeout && slave_now && (bit_cnt == CW'(FIRST_DATA));
  wire [DATA_W-1:0] src = hold_full ? hold : {DATA_W{1'b1}};
  wire accept  = tx_load && !hold_full;

  assign tx_ready = !hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sy <= '1;
      din_sy <= '1;
      clk_q  <= 1'b1;
    end else begin
      clk_sy <= {clk_sy[SYNC_STAGES-2:0], link_clk};
      din_sy <= {din_sy[SYNC_STAGES-2:0], link_din};
      clk_q  <= lclk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idle_cnt <= '0;
    else if (rise || fall) idle_cnt <= '0;
    else if (idle_cnt != IW'(IDLE_CYC)) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full   <= 1'b0;
      hold        <= '0;
      tx_underrun <= 1'b0;
    end else begin
      if (take) hold_full <= 1'b0;
      if (accept) begin
        hold      <= tx_data;
        hold_full <= 1'b1;
        tx_underrun <= 1'b0;
      end
      if (take && !hold_full) tx_underrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      ctrl_q    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '1;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      link_oe   <= 1'b0;
      link_dout <= 1'b1;
    end else begin
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      if (timeout) begin
        bit_cnt <= '0;
        link_oe <= 1'b0;
      end else if (rise) begin
        if (bit_cnt == '0) begin
          if (!ldin) bit_cnt <= 1'b1;
        end else if (bit_cnt < CW'(FIRST_DATA)) begin
          ctrl_q  <= {ctrl_q[CTRL_BITS-2:0], ldin};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (bit_cnt < CW'(LAST_BIT)) begin
          rx_sh   <= {ldin, rx_sh[DATA_W-1:1]};
          bit_cnt <= bit_cnt + 1'b1;
        end else begin
          bit_cnt <= '0;
          if (!ldin) frame_err <= 1'b1;
          else if (!slave_now) begin
            rx_valid <= 1'b1;
            rx_data  <= rx_sh;
          end
        end
      end else if (fall) begin
        if (take) begin
          link_oe   <= 1'b1;
          link_dout <= src[0];
          tx_sh     <= {1'b1, src[DATA_W-1:1]};
        end else if (link_oe && bit_cnt > CW'(FIRST_DATA) && bit_cnt < CW'(LAST_BIT)) begin
          link_dout <= tx_sh[0];
          tx_sh     <= {1'b1, tx_sh[DATA_W-1:1]};
        end else if (bit_cnt == CW'(LAST_BIT)) begin
          link_oe <= 1'b0;
        end
      end
    end
  end

  AST_STRB_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && frame_err)); // R4
  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_oe) |-> $past(fall)); // R6
  AST_RX_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !link_oe); // R6
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (link_oe && $past(link_oe) && !$past(fall)) |-> $stable(link_dout)); // R7
  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && tx_ready) |=> !tx_ready); // R8
  AST_UNDERRUN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(link_oe) && tx_underrun) |-> link_dout); // R9

endmodule

// File: tb/hdx_frame_slave_tb.sv
module hdx_frame_slave_tb_top;
  localparam int DW   = 8;
  localparam int IDLE = 64;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_clk = 1'b1, link_din = 1'b1;
  logic link_dout, link_oe, rx_valid, tx_ready, tx_underrun, frame_err;
  logic [DW-1:0] rx_data, tx_data = '0;
  logic tx_load = 1'b0;

  int checks = 0, errors = 0;
  int rx_cnt = 0, err_cnt = 0;

  always #10 clk = ~clk;

  hdx_frame_slave #(.DATA_W(DW), .IDLE_CYC(IDLE), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .link_clk(link_clk), .link_din(link_din),
    .link_dout(link_dout), .link_oe(link_oe), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_data(tx_data), .tx_load(tx_load),
    .tx_ready(tx_ready), .tx_underrun(tx_underrun), .frame_err(frame_err));

  always @(negedge clk) begin
    if (rx_valid) rx_cnt++;
    if (frame_err) err_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit slave_code(input logic [1:0] c);
    return c == 2'b11;
  endfunction

  function automatic logic line_bit(input int k, input bit sb, input logic [1:0] c,
                                    input logic [7:0] d, input bit eb);
    if (k == 0) return sb;
    if (k == 1) return c[1];
    if (k == 2) return c[0];
    if (k == 11) return eb;
    if (slave_code(c)) return 1'b1;
    return d[k-3];
  endfunction

  function automatic logic [1:0] host_code();
    logic [1:0] c;
    c = 2'($urandom_range(0, 2));
    return c;
  endfunction

  task automatic frame(input bit sb, input logic [1:0] c, input logic [7:0] d,
                       input bit eb, input int nbits, input bit idle_after,
                       output logic [7:0] got, output int oe_bad);
    got = '1;
    oe_bad = 0;
    for (int k = 0; k < nbits; k++) begin
      link_clk = 1'b0;
      link_din = line_bit(k, sb, c, d, eb);
      repeat (HALF - 1) @(negedge clk);
      if (link_oe !== (slave_code(c) && k >= 3 && k <= 10)) oe_bad++;
      if (k >= 3 && k <= 10) got[k-3] = link_dout;
      @(negedge clk);
      link_clk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    link_din = 1'b1;
    if (idle_after) repeat (IDLE + 12) @(negedge clk);
    else repeat (4) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] d);
    tx_data = d;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got, d, prev;
    int oeb, rc, ec;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(link_oe == 0 && rx_valid == 0 && frame_err == 0, "R1 outputs", link_oe, 0);
    check(tx_ready == 1 && tx_underrun == 0 && link_dout == 1, "R1 tx side", tx_ready, 1);

    // R3 random host frames
    for (int i = 0; i < 30; i++) begin
      d = 8'($urandom);
      rc = rx_cnt;
      frame(1'b0, host_code(), d, 1'b1, 12, 1'b1, got, oeb);
      check(rx_cnt == rc + 1, "R3 strobe", rx_cnt - rc, 1);
      check(rx_data == d, "R3 byte", rx_data, d);
      check(oeb == 0, "R6 no drive in host frame", oeb, 0);
    end
    // R3 directed LSB-first pattern
    frame(1'b0, 2'b00, 8'h01, 1'b1, 12, 1'b1, got, oeb);
    check(rx_data == 8'h01, "R3 lsb first", rx_data, 8'h01);

    // R5 random slave frames
    for (int i = 0; i < 30; i++) begin
      d = 8'($urandom);
      load(d);
      check(tx_ready == 0, "R8 ready drops", tx_ready, 0);
      rc = rx_cnt;
      frame(1'b0, 2'b11, 8'h00, 1'b1, 12, 1'b1, got, oeb);
      check(got == d, "R5 sent byte", got, d);
      check(oeb == 0, "R6 drive window", oeb, 0);
      check(rx_cnt == rc, "R5 no strobe", rx_cnt - rc, 0);
      check(tx_ready == 1, "R8 slot empties", tx_ready, 1);
    end
    load(8'h80);
    frame(1'b0, 2'b11, 8'h00, 1'b1, 12, 1'b1, got, oeb);
    check(got == 8'h80, "R5 msb last", got, 8'h80);

    // R4 bad end bit
    prev = rx_data;
    rc = rx_cnt; ec = err_cnt;
    frame(1'b0, 2'b01, 8'h5a, 1'b0, 12, 1'b1, got, oeb);
    check(err_cnt == ec + 1, "R4 error pulse", err_cnt - ec, 1);
    check(rx_cnt == rc && rx_data == prev, "R4 byte dropped", rx_data, prev);

    // R9 underrun
    frame(1'b0, 2'b11, 8'h00, 1'b1, 12, 1'b1, got, oeb);
    check(got == 8'hFF, "R9 fill byte", got, 8'hFF);
    check(tx_underrun == 1, "R9 flag set", tx_underrun, 1);
    load(8'h3c);
    check(tx_underrun == 0, "R9 flag cleared", tx_underrun, 0);

    // R8 load while full ignored
    load(8'hc3);
    frame(1'b0, 2'b11, 8'h00, 1'b1, 12, 1'b1, got, oeb);
    check(got == 8'h3c, "R8 second load ignored", got, 8'h3c);

    // R2 stray pulse with line high, then frame without idle gap
    rc = rx_cnt; ec = err_cnt;
    frame(1'b1, 2'b00, 8'h00, 1'b1, 1, 1'b0, got, oeb);
    frame(1'b0, 2'b10, 8'ha7, 1'b1, 12, 1'b1, got, oeb);
    check(rx_cnt == rc + 1 && rx_data == 8'ha7, "R2 start hunt", rx_data, 8'ha7);
    check(err_cnt == ec, "R2 no error", err_cnt - ec, 0);

    // R10 truncated slave frame then idle
    load(8'h96);
    frame(1'b0, 2'b11, 8'h00, 1'b1, 6, 1'b1, got, oeb);
    check(link_oe == 0, "R10 driver released", link_oe, 0);
    rc = rx_cnt;
    frame(1'b0, 2'b00, 8'h4e, 1'b1, 12, 1'b1, got, oeb);
    check(rx_cnt == rc + 1 && rx_data == 8'h4e, "R10 resync", rx_data, 8'h4e);
    check(oeb == 0, "R10 no stale drive", oeb, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule